// File: doc/BRIEF.md
# Differential Bus Activity/Idle Detector

This block is the digital back end of a differential bus receiver. It takes four already-sampled comparator outputs from an analog front end:

- above the positive activity threshold;
- below the negative activity threshold;
- above the Data1 threshold;
- below the Data0 threshold.

It turns them into a filtered bus state, idle or active, and drives the receive-data line that goes to the protocol controller.

Two separate time filters, both counted in clock cycles, decide when the bus changes state. The activity filter decides when the receive line is released from its idle-high level. The idle filter decides when the line is forced high again. Data is decoded only while activity is confirmed. The block works only while the transceiver is in its normal operating mode, which arrives as an input. In any other mode the receiver is quiet and the receive line stays high.

Top module: `bus_rx_detect`

## Requirements
- R1: While `rstN` is low, and right after it is released, `busActive` is 0 and `rxData` is 1.
- R2: While idle in normal mode, `busActive` becomes 1 on the clock edge where `aboveActHi` or `belowActLo` has been sampled high on `ACT_CYCLES` consecutive edges. It does not become 1 one edge sooner.
- R3: Any edge where both activity inputs are sampled low, while idle, restarts the activity count from zero.
- R4: While active in normal mode, `busActive` becomes 0 on the edge where both activity inputs have been sampled low on `IDLE_CYCLES` consecutive edges. Any edge with an activity input high restarts that count.
- R5: Whenever `busActive` is 0, `rxData` is 1.
- R6: On every edge that leaves `busActive` at 1, including the edge that declares activity, `rxData` takes 1 if `aboveData1` is sampled high. Otherwise it takes 0 if `belowData0` is sampled high.
- R7: While active, an edge with both data inputs low leaves `rxData` unchanged. If both data inputs are high, `aboveData1` wins and `rxData` is 1.
- R8: An edge with `normalMode` low sets `busActive` to 0 and `rxData` to 1. Activity seen while `normalMode` is low does not count toward R2.
- R9: On the edge that declares idle, `rxData` is set to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| normalMode | input | 1 | High while the transceiver is in normal operating mode |
| aboveActHi | input | 1 | Differential voltage above the positive activity threshold |
| belowActLo | input | 1 | Differential voltage below the negative activity threshold |
| aboveData1 | input | 1 | Differential voltage above the Data1 threshold |
| belowData0 | input | 1 | Differential voltage below the Data0 threshold |
| rxData | output | 1 | Receive data toward the protocol controller; high while idle |
| busActive | output | 1 | Filtered bus state, 1 when activity is confirmed |

## Verification
The bench builds the block with `ACT_CYCLES` = 3 and `IDLE_CYCLES` = 2. With filters this short, the exact declaring edge, the edge one before it, and restarts at every position of the count can all be reached in a few cycles.

Directed sequences cover each boundary and the mode drop. After that, a long sweep of held input patterns, with run lengths on both sides of each filter length, is compared edge by edge against an arithmetic model kept in the bench.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

  // Strobes passed from the control to the data path each cycle.
  typedef struct packed {
    logic active;     // registered bus state (1 = activity confirmed)
    logic goActive;   // this edge declares activity
    logic goIdle;     // this edge declares idle
    logic forceHigh;  // receiver disabled (not in normal mode)
  } rxStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rxdet_ctrl.sv
module rxdet_ctrl
  import rxdet_pkg::*;
#(
  parameter int ACT_CYCLES  = 10,
  parameter int IDLE_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       normalMode,
  input  logic       aboveActHi,
  input  logic       belowActLo,
  output rxStrobe_t  stb
);

  localparam int MAX_LEN = maxOf(ACT_CYCLES, IDLE_CYCLES);
  localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN + 1) : 1;
  localparam logic [CNT_W-1:0] ACT_LAST  = CNT_W'(ACT_CYCLES - 1);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYCLES - 1);

  logic             stateActive;
  logic [CNT_W-1:0] runCnt;
  logic             actCond;
  logic             goActive;
  logic             goIdle;

  assign actCond  = aboveActHi | belowActLo;
  assign goActive = normalMode & ~stateActive &  actCond & (runCnt == ACT_LAST);
  assign goIdle   = normalMode &  stateActive & ~actCond & (runCnt == IDLE_LAST);

  // One run counter serves both filters; its meaning follows the state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateActive <= 1'b0;
      runCnt      <= '0;
    end else if (!normalMode) begin
      stateActive <= 1'b0;
      runCnt      <= '0;
    end else if (!stateActive) begin
      if (!actCond) begin
        runCnt <= '0;
      end else if (goActive) begin
        stateActive <= 1'b1;
        runCnt      <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end else begin
      if (actCond) begin
        runCnt <= '0;
      end else if (goIdle) begin
        stateActive <= 1'b0;
        runCnt      <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.active    = stateActive;
    stb.goActive  = goActive;
    stb.goIdle    = goIdle;
    stb.forceHigh = ~normalMode;
  end

  // R2: the counter never passes the longest filter
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    runCnt < CNT_W'(MAX_LEN));

  // R8: leaving normal mode always drops the state
  assert_standby_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !normalMode |=> !stateActive);

  // R2: activity is only declared after activity was sampled
  assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stateActive) |-> $past(actCond) && $past(normalMode));

  // R4: idle comes only from quiet input or a mode drop
  assert_fall_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stateActive) |-> ($past(!actCond) || $past(!normalMode)));

endmodule

// File: rtl/rxdet_datapath.sv
module rxdet_datapath
  import rxdet_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rxStrobe_t  stb,
  input  logic       aboveData1,
  input  logic       belowData0,
  output logic       rxData
);

  logic decodeEn;
  logic nextData;

  assign decodeEn = (stb.active & ~stb.goIdle) | stb.goActive;

  // Data1 has priority; neither comparator means hold.
  always_comb begin
    if (aboveData1)      nextData = 1'b1;
    else if (belowData0) nextData = 1'b0;
    else                 nextData = rxData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= 1'b1;
    end else if (stb.forceHigh || stb.goIdle) begin
      rxData <= 1'b1;
    end else if (decodeEn) begin
      rxData <= nextData;
    end else begin
      rxData <= 1'b1;
    end
  end

  // R5: output high whenever the registered state is idle
  assert_high_when_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.active |-> rxData);

  // R6: a low output must come from the Data0 comparator
  assert_low_from_data0_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxData) |-> $past(belowData0) && !$past(aboveData1));

  // R7: in steady activity with no data input the output holds
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.active && !stb.goIdle && !stb.forceHigh && !aboveData1 && !belowData0)
      |=> $stable(rxData));

endmodule

// File: rtl/bus_rx_detect.sv
module bus_rx_detect
  import rxdet_pkg::*;
#(
  parameter int ACT_CYCLES  = 10,
  parameter int IDLE_CYCLES = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic normalMode,
  input  logic aboveActHi,
  input  logic belowActLo,
  input  logic aboveData1,
  input  logic belowData0,
  output logic rxData,
  output logic busActive
);

  rxStrobe_t stb;

  rxdet_ctrl #(
    .ACT_CYCLES (ACT_CYCLES),
    .IDLE_CYCLES(IDLE_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .normalMode(normalMode),
    .aboveActHi(aboveActHi),
    .belowActLo(belowActLo),
    .stb       (stb)
  );

  rxdet_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .aboveData1(aboveData1),
    .belowData0(belowData0),
    .rxData    (rxData)
  );

  assign busActive = stb.active;

  initial begin
    assert (ACT_CYCLES >= 1 && IDLE_CYCLES >= 1);
  end

endmodule

// File: tb/bus_rx_detect_bench.sv
module bus_rx_detect_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ACT  = 3;
  localparam int IDLE = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic normalMode = 1'b0;
  logic aboveActHi = 1'b0, belowActLo = 1'b0, aboveData1 = 1'b0, belowData0 = 1'b0;
  logic rxData, busActive;

  int checks = 0;
  int fails = 0;

  // reference model state
  bit mActive = 0;
  bit mRx = 1;
  int mCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_rx_detect #(.ACT_CYCLES(ACT), .IDLE_CYCLES(IDLE)) u_bus_rx_detect (
    .clk(clk), .rstN(rstN), .normalMode(normalMode),
    .aboveActHi(aboveActHi), .belowActLo(belowActLo),
    .aboveData1(aboveData1), .belowData0(belowData0),
    .rxData(rxData), .busActive(busActive)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // model of one edge, built from the requirement text
  task automatic modelEdge(input bit m, input bit [3:0] v);
    bit act, d1, d0, declare;
    act = v[3] | v[2];
    d1 = v[1];
    d0 = v[0];
    if (!m) begin
      mActive = 0; mCnt = 0; mRx = 1;
    end else if (!mActive) begin
      if (act) begin
        mCnt++;
        if (mCnt == ACT) begin
          mActive = 1; mCnt = 0;
          if (d1) mRx = 1; else if (d0) mRx = 0;
        end
      end else mCnt = 0;
      if (!mActive) mRx = 1;
    end else begin
      declare = 0;
      if (!act) begin
        mCnt++;
        if (mCnt == IDLE) begin mActive = 0; mCnt = 0; mRx = 1; declare = 1; end
      end else mCnt = 0;
      if (!declare) begin
        if (d1) mRx = 1; else if (d0) mRx = 0;
      end
    end
  endtask

  // v = {aboveActHi, belowActLo, aboveData1, belowData0}
  task automatic step(input string tagA, input string tagR, input bit m, input bit [3:0] v);
    @(negedge clk);
    normalMode = m;
    {aboveActHi, belowActLo, aboveData1, belowData0} = v;
    @(posedge clk);
    #1;
    modelEdge(m, v);
    check(tagA, busActive, mActive);
    check(tagR, rxData, mRx);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    #(CLK_PERIOD * 2 + 1);
    check("R1 busActive in reset", busActive, 1'b0);
    check("R1 rxData in reset", rxData, 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 busActive after reset", busActive, 1'b0);
    check("R1 rxData after reset", rxData, 1'b1);

    // R3: run broken one edge short
    step("R3", "R5", 1, 4'b1010);
    step("R3", "R5", 1, 4'b1010);
    step("R3", "R5", 1, 4'b0000);
    step("R3", "R5", 1, 4'b0101);
    step("R2 one short", "R5", 1, 4'b0101);
    check("R2 not yet active", busActive, 1'b0);
    // R2 / R6: declaring edge decodes Data0
    step("R2 declare", "R6 decode on declare", 1, 4'b0101);
    check("R2 active now", busActive, 1'b1);
    check("R6 low on declare", rxData, 1'b0);
    // R7: hold and priority
    step("R4", "R7 hold", 1, 4'b1000);
    check("R7 held low", rxData, 1'b0);
    step("R4", "R7 priority", 1, 4'b1011);
    check("R7 Data1 wins", rxData, 1'b1);
    step("R4", "R6", 1, 4'b0101);
    // R4: idle run restarted
    step("R4 restart", "R7", 1, 4'b0000);
    step("R4 restart", "R6", 1, 4'b1010);
    step("R4 one short", "R7", 1, 4'b0000);
    check("R4 still active", busActive, 1'b1);
    step("R4 declare idle", "R9", 1, 4'b0000);
    check("R4 idle now", busActive, 1'b0);
    check("R9 high on idle", rxData, 1'b1);
    // R8: mode drop
    for (int i = 0; i < ACT; i++) step("R2", "R6", 1, 4'b0101);
    check("R8 precondition", busActive, 1'b1);
    step("R8 drop", "R8 high", 0, 4'b0101);
    check("R8 inactive", busActive, 1'b0);
    for (int i = 0; i < ACT + 2; i++) step("R8 no count", "R8", 0, 4'b0101);
    step("R8 restart count", "R5", 1, 4'b0101);
    check("R8 counting anew", busActive, 1'b0);

    // sweep of held patterns against the model
    for (int n = 0; n < 3000; n++) begin
      bit [3:0] v;
      bit m;
      int len;
      v = 4'($urandom_range(0, 15));
      m = ($urandom_range(0, 15) != 0);
      len = $urandom_range(1, ACT + 2);
      for (int k = 0; k < len; k++) step("R2 sweep", "R6 sweep", m, v);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule